// File: doc/BRIEF.md
# Sequenced Gate Delay and Width Generator

This block turns a trigger edge into one gate pulse. The pulse starts a programmable number of clock cycles after the trigger and stays high for a programmable number of cycles. The counting is done on a 1 ns time base, so one clock cycle stands for 1 ns. Delay/width pairs are kept in a table that is loaded through a write port. Each write is checked before it is stored. A width that is too short or has the wrong step is refused, and so is a pair whose delay plus width is above the time limit. A refused write raises the error output and leaves the table unchanged.

With the sequence enable low, every trigger uses table entry 0. When the sequence enable is raised, the block first scans the active part of the table. It arms only if every width in that part falls in one width band. Once armed, each accepted trigger takes the next entry and the index wraps after the last active entry. In this mode, a trigger that comes too soon after the previous accepted trigger is dropped. The inhibit input and a gate cycle already in progress also block triggers.

Top module: `gate_seq_gen`

## Requirements
- R1: A trigger is first sampled high at clock edge E0 and is accepted there. The gate then rises at edge E0+D+1 and stays high for exactly W cycles, where D and W are the delay and width of the selected entry.
- R2: The busy output rises at the edge that accepts a trigger and falls at the same edge as the gate. The gate is never high while busy is low. After reset, gate, busy, armed and err are all 0.
- R3: A rising trigger edge that arrives while busy is high is ignored and produces no gate.
- R4: While inhibit is 1, trigger edges are ignored. Tie inhibit to 0 when it is not used.
- R5: A write is refused if the width is below MIN_W (4), or if the width is below 15 and odd. A refused write sets err to 1 at the write edge and leaves the entry unchanged.
- R6: A write whose delay plus width is greater than SUM_LIMIT is refused and sets err. A sum equal to SUM_LIMIT is accepted.
- R7: An accepted write clears err at the write edge.
- R8: Raising seq_en starts a scan of entries 0 to seq_len-1. The widths fall into three bands: below 15, 15 to 199, and 200 or more. If all scanned widths share one band, armed goes high. If they do not, or if seq_len is 0 or greater than MAX_ENTRIES, err goes to 1 and armed stays 0. Triggers are ignored while seq_en is high and armed is low.
- R9: While armed, each accepted trigger uses the current entry and then advances the index. After entry seq_len-1 the index wraps to 0.
- R10: While armed, a trigger that comes fewer than RATE_GAP cycles after the previous accepted trigger is dropped, and the index does not advance.
- R11: The index returns to 0 when seq_en is low and after any accepted write. An accepted write while seq_en is high restarts the scan.
- R12: With seq_en low, every trigger uses entry 0 and there is no rate limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per time unit |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger; a rising edge requests a gate |
| inhibit | input | 1 | High blocks triggers |
| seq_en | input | 1 | Sequence mode enable; a rising edge starts the band scan |
| seq_len | input | $clog2(MAX_ENTRIES) | Number of active table entries |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(MAX_ENTRIES) | Entry to write |
| wr_delay | input | CNT_W | Delay in cycles |
| wr_width | input | CNT_W | Width in cycles |
| gate | output | 1 | Gate pulse |
| busy | output | 1 | A gate cycle is in progress |
| armed | output | 1 | Sequence scanned and ready |
| err | output | 1 | Last write refused, or the last scan failed |

## Verification
The assertions assume that trig_in, inhibit, seq_en and the write inputs change only between clock edges. They also assume that seq_en is not dropped in the same cycle as an accepted trigger. The rate check counts cycles between busy rises, so it assumes that no trigger from single mode lands within RATE_GAP cycles before the first armed trigger. The stimulus changes every input on the falling edge. It leaves long idle gaps after each mode change and between armed triggers, except for the one trigger that is meant to be dropped. It holds seq_en steady around every trigger.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  localparam int BAND_MID_MIN  = 15;
  localparam int BAND_WIDE_MIN = 200;

  typedef enum logic [1:0] {
    BAND_NARROW = 2'd0,
    BAND_MID    = 2'd1,
    BAND_WIDE   = 2'd2
  } band_t;

  typedef enum logic [1:0] {
    MD_OFF   = 2'd0,
    MD_SCAN  = 2'd1,
    MD_ARMED = 2'd2,
    MD_FAULT = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    TM_IDLE = 2'd0,
    TM_DLY  = 2'd1,
    TM_WID  = 2'd2
  } tmr_state_t;

  function automatic band_t width_band(input logic [31:0] w);
    if (w < 32'(BAND_MID_MIN))       return BAND_NARROW;
    else if (w < 32'(BAND_WIDE_MIN)) return BAND_MID;
    else                             return BAND_WIDE;
  endfunction

endpackage

// File: rtl/gate_seq_table.sv
module gate_seq_table
  import gate_seq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CNT_W-1:0] wdelay,
  input  logic [CNT_W-1:0] wwidth,
  input  logic [IDX_W-1:0] raddr,
  output logic [CNT_W-1:0] rdelay,
  output logic [CNT_W-1:0] rwidth,
  input  logic [IDX_W-1:0] baddr,
  output band_t            bband
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int WORD_W = 2 * CNT_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;
  band_t             band_mem [DEPTH];

  // Pair storage: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wdelay, wwidth};
    rd_q <= mem[raddr];
  end

  // Band tags kept beside the pairs for the arm-time scan.
  always_ff @(posedge clk) begin
    if (we) band_mem[waddr] <= width_band(32'(wwidth));
  end

  assign rdelay = rd_q[WORD_W-1:CNT_W];
  assign rwidth = rd_q[CNT_W-1:0];
  assign bband  = band_mem[baddr];

endmodule

// File: rtl/gate_seq_check.sv
module gate_seq_check
  import gate_seq_pkg::*;
#(
  parameter int CNT_W       = 27,
  parameter int IDX_W       = 8,
  parameter int MAX_ENTRIES = 250,
  parameter int MIN_W       = 4,
  parameter int SUM_LIMIT   = 80_000_000
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] width,
  output logic             ok
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] total;
  logic             too_short;
  logic             odd_narrow;
  logic             too_long;
  logic             bad_idx;

  always_comb begin
    total      = {1'b0, delay} + {1'b0, width};
    too_short  = width < CNT_W'(MIN_W);
    odd_narrow = (width < CNT_W'(BAND_MID_MIN)) && width[0];
    too_long   = total > SUM_W'(SUM_LIMIT);
    bad_idx    = 32'(idx) >= MAX_ENTRIES;
    ok         = !(too_short || odd_narrow || too_long || bad_idx);
  end

endmodule

// File: rtl/gate_seq_timer.sv
module gate_seq_timer
  import gate_seq_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] dly_in,
  input  logic [CNT_W-1:0] wid_in,
  output logic             gate,
  output logic             busy
);
  tmr_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wid_q;

  // One down-counter serves first the delay phase and then the width phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TM_IDLE;
      cnt   <= '0;
      wid_q <= '0;
      gate  <= 1'b0;
      busy  <= 1'b0;
    end else begin
      case (st)
        TM_IDLE: begin
          if (start) begin
            cnt   <= dly_in;
            wid_q <= wid_in;
            busy  <= 1'b1;
            st    <= TM_DLY;
          end
        end
        TM_DLY: begin
          if (cnt == '0) begin
            gate <= 1'b1;
            cnt  <= wid_q - CNT_W'(1);
            st   <= TM_WID;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        TM_WID: begin
          if (cnt == '0) begin
            gate <= 1'b0;
            busy <= 1'b0;
            st   <= TM_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= TM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gate_seq_gen.sv
module gate_seq_gen
  import gate_seq_pkg::*;
#(
  parameter int CNT_W       = 27,
  parameter int MAX_ENTRIES = 250,
  parameter int MIN_W       = 4,
  parameter int SUM_LIMIT   = 80_000_000,
  parameter int RATE_GAP    = 526_316
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           trig_in,
  input  logic                           inhibit,
  input  logic                           seq_en,
  input  logic [$clog2(MAX_ENTRIES)-1:0] seq_len,
  input  logic                           wr_en,
  input  logic [$clog2(MAX_ENTRIES)-1:0] wr_idx,
  input  logic [CNT_W-1:0]               wr_delay,
  input  logic [CNT_W-1:0]               wr_width,
  output logic                           gate,
  output logic                           busy,
  output logic                           armed,
  output logic                           err
);
  localparam int IDX_W = $clog2(MAX_ENTRIES);
  localparam int GAP_W = $clog2(RATE_GAP + 1);

  logic             trig_q;
  logic             seq_en_q;
  logic             wr_ok;
  logic             wr_accept;
  logic             fire;
  logic             len_ok;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] scan_ptr;
  band_t            scan_band;
  band_t            ref_band;
  logic [GAP_W-1:0] gap_cnt;
  mode_t            mode;
  logic [CNT_W-1:0] rd_delay;
  logic [CNT_W-1:0] rd_width;

  gate_seq_check #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES),
    .MIN_W(MIN_W), .SUM_LIMIT(SUM_LIMIT)
  ) check_i (
    .idx(wr_idx), .delay(wr_delay), .width(wr_width), .ok(wr_ok)
  );

  gate_seq_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) table_i (
    .clk(clk), .we(wr_accept), .waddr(wr_idx),
    .wdelay(wr_delay), .wwidth(wr_width),
    .raddr(idx), .rdelay(rd_delay), .rwidth(rd_width),
    .baddr(scan_ptr), .bband(scan_band)
  );

  gate_seq_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .start(fire),
    .dly_in(rd_delay), .wid_in(rd_width),
    .gate(gate), .busy(busy)
  );

  assign wr_accept = wr_en && wr_ok;
  assign len_ok    = (seq_len != '0) && (32'(seq_len) <= MAX_ENTRIES);
  assign armed     = (mode == MD_ARMED);

  always_comb begin
    fire = trig_in && !trig_q && !inhibit && !busy;
    if (seq_en) fire = fire && (mode == MD_ARMED) && (gap_cnt == '0);
  end

  // Trigger edge, rate guard and sequence index.
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= 1'b0;
      gap_cnt <= '0;
      idx     <= '0;
    end else begin
      trig_q <= trig_in;
      if (fire)                gap_cnt <= GAP_W'(RATE_GAP - 1);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - GAP_W'(1);
      if (!seq_en || wr_accept) idx <= '0;
      else if (fire)            idx <= (idx == seq_len - IDX_W'(1)) ? '0 : idx + IDX_W'(1);
    end
  end

  // Mode control, band scan and error flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MD_OFF;
      seq_en_q <= 1'b0;
      scan_ptr <= '0;
      ref_band <= BAND_NARROW;
      err      <= 1'b0;
    end else begin
      seq_en_q <= seq_en;
      if (wr_en) err <= !wr_ok;
      if (!seq_en) begin
        mode <= MD_OFF;
      end else if (!seq_en_q || wr_accept) begin
        mode     <= MD_SCAN;
        scan_ptr <= '0;
      end else if (mode == MD_SCAN) begin
        if (!len_ok) begin
          mode <= MD_FAULT;
          err  <= 1'b1;
        end else if (scan_ptr == seq_len) begin
          mode <= MD_ARMED;
        end else begin
          if (scan_ptr == '0) begin
            ref_band <= scan_band;
          end else if (scan_band != ref_band) begin
            mode <= MD_FAULT;
            err  <= 1'b1;
          end
          scan_ptr <= scan_ptr + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk #(
  parameter int CNT_W    = 27,
  parameter int MIN_W    = 4,
  parameter int RATE_GAP = 526_316
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_in,
  input logic             inhibit,
  input logic             seq_en,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_width,
  input logic             gate,
  input logic             busy,
  input logic             armed,
  input logic             err
);
  localparam int GW = $clog2(RATE_GAP + 1);

  logic          busy_q;
  logic [GW-1:0] since;
  logic          busy_rise;

  assign busy_rise = busy && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      since  <= GW'(RATE_GAP);
    end else begin
      busy_q <= busy;
      if (busy_rise)                 since <= GW'(1);
      else if (since < GW'(RATE_GAP)) since <= since + GW'(1);
    end
  end

  // R2
  gate_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    gate |-> busy);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(gate));

  // R3
  trig_fire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(trig_in) && !$past(busy)));

  // R4
  inhibit_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(inhibit));

  // R5
  short_width_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_width < CNT_W'(MIN_W))) |=> err);

  // R8
  armed_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> $past(seq_en));

  // R10
  rate_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_rise && $past(armed && seq_en)) |-> (since >= GW'(RATE_GAP)));

endmodule

bind gate_seq_gen gate_seq_chk #(
  .CNT_W(CNT_W), .MIN_W(MIN_W), .RATE_GAP(RATE_GAP)
) chk_i (
  .clk(clk), .rst(rst), .trig_in(trig_in), .inhibit(inhibit),
  .seq_en(seq_en), .wr_en(wr_en), .wr_width(wr_width),
  .gate(gate), .busy(busy), .armed(armed), .err(err)
);

// File: tb/gate_seq_gen_tb.sv
module gate_seq_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 27;
  localparam int MAXE       = 250;
  localparam int IW         = $clog2(MAXE);
  localparam int SUML       = 1000;
  localparam int GAP        = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0, inhibit = 1'b0, seq_en = 1'b0, wr_en = 1'b0;
  logic [IW-1:0]    seq_len = '0, wr_idx = '0;
  logic [CNT_W-1:0] wr_delay = '0, wr_width = '0;
  logic gate, busy, armed, err;

  int cyc = 0;
  int nvec = 0;
  int nfail = 0;
  int exp_rise[$];
  int exp_w[$];
  logic gate_prev = 1'b0;
  int rise_at = 0;

  gate_seq_gen #(
    .CNT_W(CNT_W), .MAX_ENTRIES(MAXE), .MIN_W(4),
    .SUM_LIMIT(SUML), .RATE_GAP(GAP)
  ) dut_i (
    .clk(clk), .rst(rst), .trig_in(trig_in), .inhibit(inhibit),
    .seq_en(seq_en), .seq_len(seq_len), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_delay(wr_delay), .wr_width(wr_width),
    .gate(gate), .busy(busy), .armed(armed), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  // Monitor: measure each gate and compare with the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (gate && !gate_prev) rise_at = cyc;
      if (!gate && gate_prev) begin
        if (exp_rise.size() == 0) begin
          chk(1'b0, "R1/R3/R4/R10 unexpected gate", rise_at, -1);
        end else begin
          int er, ew;
          er = exp_rise.pop_front();
          ew = exp_w.pop_front();
          chk(rise_at == er, "R1 gate rise cycle", rise_at, er);
          chk((cyc - rise_at) == ew, "R1 gate width", cyc - rise_at, ew);
        end
      end
      gate_prev = gate;
    end
  end

  task automatic wr(input int i, input int d, input int w);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(i); wr_delay = CNT_W'(d); wr_width = CNT_W'(w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(input bit expect_gate, input int d, input int w);
    @(negedge clk);
    trig_in = 1'b1;
    if (expect_gate) begin
      exp_rise.push_back(cyc + 1 + d + 1);
      exp_w.push_back(w);
    end
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R2 reset state
    chk(!gate && !busy, "R2 reset gate/busy", {gate, busy}, 0);
    chk(!armed && !err, "R8 reset armed/err", {armed, err}, 0);

    // R1, R7 single trigger
    wr(0, 10, 20);
    chk(err == 1'b0, "R7 good write clears err", err, 0);
    fire(1, 10, 20);
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    // R3 trigger while busy
    idle(3);
    fire(0, 10, 20);
    idle(40);
    // R12 close triggers in single mode
    fire(1, 10, 20);
    idle(35);
    fire(1, 10, 20);
    idle(40);

    // R1 zero delay, minimum width
    wr(0, 0, 4);
    fire(1, 0, 4);
    idle(10);

    // R5 short and odd-narrow widths refused, entry kept
    wr(0, 5, 3);
    chk(err == 1'b1, "R5 width below minimum", err, 1);
    fire(1, 0, 4);
    idle(10);
    wr(0, 5, 13);
    chk(err == 1'b1, "R5 odd narrow width", err, 1);
    wr(0, 5, 14);
    chk(err == 1'b0, "R7 even narrow accepted", err, 0);
    fire(1, 5, 14);
    idle(25);

    // R6 sum limit
    wr(0, 500, 501);
    chk(err == 1'b1, "R6 sum over limit", err, 1);
    wr(0, 500, 500);
    chk(err == 1'b0, "R6 sum at limit", err, 0);
    fire(1, 500, 500);
    idle(1010);

    // R4 inhibit
    inhibit = 1'b1;
    fire(0, 500, 500);
    chk(busy == 1'b0, "R4 inhibited trigger", busy, 0);
    idle(20);
    inhibit = 1'b0;

    // R8, R9 sequence with wrap
    wr(0, 5, 20);
    wr(1, 8, 30);
    wr(2, 3, 199);
    seq_len = IW'(3);
    seq_en = 1'b1;
    idle(10);
    chk(armed == 1'b1, "R8 single band arms", armed, 1);
    fire(1, 5, 20);  idle(210);
    fire(1, 8, 30);  idle(210);
    fire(1, 3, 199); idle(210);
    fire(1, 5, 20);  // R9 wrap to entry 0
    idle(50);
    // R10 too soon: dropped, index kept
    fire(0, 8, 30);
    chk(busy == 1'b0, "R10 early trigger dropped", busy, 0);
    idle(210);
    fire(1, 8, 30);  idle(210);

    // R11 clearing seq_en resets index
    seq_en = 1'b0;
    idle(3);
    seq_en = 1'b1;
    idle(10);
    fire(1, 5, 20);  idle(210);
    fire(1, 8, 30);  idle(210);
    // R11 accepted write resets index and rescans
    wr(2, 3, 198);
    idle(10);
    chk(armed == 1'b1, "R11 rescan after write", armed, 1);
    fire(1, 5, 20);  idle(210);

    // R8 mixed bands
    wr(1, 8, 12);
    idle(10);
    chk(armed == 1'b0, "R8 mixed bands not armed", armed, 0);
    chk(err == 1'b1, "R8 mixed bands err", err, 1);
    fire(0, 5, 20);
    idle(30);

    // R8 zero length
    seq_en = 1'b0;
    wr(1, 8, 30);
    seq_len = '0;
    seq_en = 1'b1;
    idle(10);
    chk(armed == 1'b0 && err == 1'b1, "R8 zero length", {armed, err}, 1);
    seq_en = 1'b0;

    // R9 one wide entry repeats
    wr(0, 2, 300);
    seq_len = IW'(1);
    seq_en = 1'b1;
    idle(10);
    chk(armed == 1'b1, "R8 one wide entry arms", armed, 1);
    fire(1, 2, 300); idle(320);
    fire(1, 2, 300); idle(320);

    chk(exp_rise.size() == 0, "R1 all expected gates seen", exp_rise.size(), 0);
    summary();
  end

endmodule